// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared memory system. For every memory block in the node's local slice of memory, it holds a directory entry with a coherence state and a sharer bit vector that has one bit per node. Remote caches send it read misses, write misses and write-backs. It answers each one with a reply that says where the data comes from: local memory, or a copy fetched from the owning cache. It also sends addressed invalidate, fetch or fetch-and-invalidate messages, but only to the nodes named in the sharer vector. Nothing is ever broadcast.

A directory entry is in one of three states. Uncached means no cache holds the block. Shared means one or more caches hold a clean copy and memory is current. Modified means a single cache holds a written copy and memory is stale. An entry changes only when a request for it is processed. The controller handles one transaction at a time. While a transaction is open, `req_ready` stays low, so a new request waits until the current one completes.

The memory data path, the network and the cache controllers are outside the block. The controller reports memory updates on `mem_wr`, and an owner's returned data is signalled on `fetch_ack`.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached with an empty sharer vector, `req_ready` is high, and `msg_valid`, `reply_valid` and `mem_wr` are low.
- R2: A read miss (`req_kind` 0) to an Uncached or Shared block sends no message and gives one reply with `reply_fwd` 0 (data from memory). The block becomes Shared, and the requester is added to the existing sharers.
- R3: A read miss to a Modified block sends one fetch message (`msg_kind` 2) to the owner and then waits for `fetch_ack`. It then pulses `mem_wr` and replies with `reply_fwd` 1. The block becomes Shared, with the owner and the requester as its sharers.
- R4: A write miss (`req_kind` 1) to a Shared block sends one invalidate (`msg_kind` 1) to every sharer except the requester. Each such node gets exactly one invalidate, and no other node gets one. The invalidates go out one per cycle in ascending node index.
- R5: A write miss to a Modified block sends one fetch-and-invalidate (`msg_kind` 3) to the owner and waits for `fetch_ack`. It then pulses `mem_wr` and replies with `reply_fwd` 1. The block becomes Modified with only the requester as sharer.
- R6: A write miss to an Uncached block, or to a Shared block whose only sharer is the requester, sends no message and replies with `reply_fwd` 0. The block becomes Modified, held by the requester.
- R7: A write-back (`req_kind` 2) from the sole holder of a Modified block pulses `mem_wr` and gives no reply. The block becomes Uncached with no sharers.
- R8: The controller ignores three kinds of request: a write-back from a node that does not own a Modified block, a write-back to a block that is not Modified, and `req_kind` 3. An ignored request sends no message, gives no reply, does not write memory, and leaves the directory entry unchanged.
- R9: From acceptance until completion, `req_ready` stays low. For a fetch, it stays low through the whole wait for `fetch_ack`, however long that is.
- R10: The directory changes only while a request is being processed. With no request pending, no message, reply or memory write is produced.
- R11: A Modified entry always has exactly one sharer bit set, an Uncached entry has none, and a Shared entry has at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_node | input | $clog2(NODES) | Requesting node |
| req_block | input | $clog2(BLOCKS) | Block index in local memory |
| fetch_ack | input | 1 | Owner's data for the open fetch has arrived |
| msg_valid | output | 1 | Addressed coherence message this cycle |
| msg_kind | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node | output | $clog2(NODES) | Destination node of the message |
| msg_block | output | $clog2(BLOCKS) | Block the message concerns |
| reply_valid | output | 1 | Reply to the requester this cycle |
| reply_node | output | $clog2(NODES) | Node the reply goes to |
| reply_block | output | $clog2(BLOCKS) | Block the reply concerns |
| reply_fwd | output | 1 | 1: data is the owner's fetched copy; 0: data from memory |
| mem_wr | output | 1 | Write the block's data into local memory this cycle |
| mem_wr_block | output | $clog2(BLOCKS) | Block written to memory |

## Verification
The bound assertions watch every cycle for the following:
- the holder-count invariant of each state on every directory write;
- invalidates never addressed to the requester and always in ascending node order;
- no directory write or message outside an open transaction;
- `req_ready` low whenever a transaction is open;
- replies lasting a single cycle.

Only the bench scenarios can show that the right set of nodes was invalidated, that fetches reach the actual owner, and that the data source and the resulting state match each request kind. The same holds for requests that are ignored. For those, the bench infers the unchanged entry from the messages produced by a later request, and it checks that a slow `fetch_ack` keeps the controller stalled.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_MOD = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_RD  = 2'd0,
    RQ_WR  = 2'd1,
    RQ_WB  = 2'd2,
    RQ_NOP = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    MK_NONE      = 2'd0,
    MK_INV       = 2'd1,
    MK_FETCH     = 2'd2,
    MK_FETCH_INV = 2'd3
  } msg_e;

  typedef enum logic [2:0] {
    EN_IDLE  = 3'd0,
    EN_EVAL  = 3'd1,
    EN_INV   = 3'd2,
    EN_FETCH = 3'd3,
    EN_WAIT  = 3'd4,
    EN_DONE  = 3'd5
  } eng_e;

  // Directory state left behind by a completed (non-dropped) request.
  function automatic dstate_e dir_after(req_e k, dstate_e s);
    case (k)
      RQ_RD:   return DS_SHR;
      RQ_WR:   return DS_MOD;
      RQ_WB:   return DS_UNC;
      default: return s;
    endcase
  endfunction

  // True when the owner's copy must be recovered before replying.
  function automatic logic needs_owner(req_e k, dstate_e s);
    return (k == RQ_RD || k == RQ_WR) && s == DS_MOD;
  endfunction

  // Message kind sent to the owner of a Modified block.
  function automatic msg_e owner_msg(req_e k);
    return (k == RQ_WR) ? MK_FETCH_INV : MK_FETCH;
  endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output dstate_e          rd_state,
  output logic [NODES-1:0] rd_sharers,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_idx,
  input  dstate_e          wr_state,
  input  logic [NODES-1:0] wr_sharers
);

  dstate_e          st_a [BLOCKS];
  logic [NODES-1:0] sh_a [BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_a[b] <= DS_UNC;
        sh_a[b] <= '0;
      end
    end else if (wr_en) begin
      st_a[wr_idx] <= wr_state;
      sh_a[wr_idx] <= wr_sharers;
    end
  end

  assign rd_state   = st_a[rd_idx];
  assign rd_sharers = sh_a[rd_idx];

endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N = 8,
  localparam int NW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [NW-1:0] idx
);

  logic [N-1:0] iso;
  assign iso = vec & (~vec + N'(1));

  for (genvar j = 0; j < NW; j++) begin : g_idx
    logic [N-1:0] m;
    always_comb begin
      for (int i = 0; i < N; i++) m[i] = ((i >> j) % 2) == 1;
    end
    assign idx[j] = |(iso & m);
  end

endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [NW-1:0]    req_node,
  input  logic [BW-1:0]    req_block,
  input  logic             fetch_ack,
  input  dstate_e          rd_state,
  input  logic [NODES-1:0] rd_sharers,
  input  logic [NW-1:0]    pick_idx,
  output logic [NODES-1:0] pick_vec,
  output logic [BW-1:0]    cur_block,
  output logic [NW-1:0]    cur_node,
  output logic             busy,
  output logic             msg_valid,
  output logic [1:0]       msg_kind,
  output logic [NW-1:0]    msg_node,
  output logic             reply_valid,
  output logic             reply_fwd,
  output logic             mem_wr,
  output logic             dir_wr_en,
  output dstate_e          dir_wr_state,
  output logic [NODES-1:0] dir_wr_sharers
);

  eng_e             st;
  req_e             k_q;
  logic [NW-1:0]    node_q;
  logic [BW-1:0]    blk_q;
  dstate_e          old_st_q;
  logic [NODES-1:0] old_sh_q;
  logic [NODES-1:0] pend_q;
  logic             fwd_q;
  logic             wb_ok_q;
  logic             drop_q;

  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] pick_bit;
  logic [NODES-1:0] pend_left;
  logic [NODES-1:0] ev_pend;
  logic             ev_owner;
  logic             ev_wb_ok;
  logic             ev_drop;

  assign req_bit   = NODES'(1) << node_q;
  assign pick_bit  = NODES'(1) << pick_idx;
  assign pend_left = pend_q & ~pick_bit;

  // Decision taken once the directory entry of the latched block is visible.
  always_comb begin
    ev_owner = needs_owner(k_q, rd_state);
    ev_pend  = '0;
    ev_wb_ok = 1'b0;
    ev_drop  = 1'b0;
    case (k_q)
      RQ_WR:   if (rd_state == DS_SHR) ev_pend = rd_sharers & ~req_bit;
      RQ_WB: begin
        ev_wb_ok = (rd_state == DS_MOD) && (rd_sharers == req_bit);
        ev_drop  = !ev_wb_ok;
      end
      RQ_NOP:  ev_drop = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= EN_IDLE;
      k_q      <= RQ_NOP;
      node_q   <= '0;
      blk_q    <= '0;
      old_st_q <= DS_UNC;
      old_sh_q <= '0;
      pend_q   <= '0;
      fwd_q    <= 1'b0;
      wb_ok_q  <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      case (st)
        EN_IDLE: if (req_valid) begin
          k_q     <= req_e'(req_kind);
          node_q  <= req_node;
          blk_q   <= req_block;
          fwd_q   <= 1'b0;
          wb_ok_q <= 1'b0;
          drop_q  <= 1'b0;
          st      <= EN_EVAL;
        end
        EN_EVAL: begin
          old_st_q <= rd_state;
          old_sh_q <= rd_sharers;
          pend_q   <= ev_pend;
          fwd_q    <= ev_owner;
          wb_ok_q  <= ev_wb_ok;
          drop_q   <= ev_drop;
          if (ev_owner)          st <= EN_FETCH;
          else if (ev_pend != 0) st <= EN_INV;
          else                   st <= EN_DONE;
        end
        EN_INV: begin
          pend_q <= pend_left;
          if (pend_left == 0) st <= EN_DONE;
        end
        EN_FETCH: st <= EN_WAIT;
        EN_WAIT:  if (fetch_ack) st <= EN_DONE;
        EN_DONE:  st <= EN_IDLE;
        default:  st <= EN_IDLE;
      endcase
    end
  end

  assign busy      = (st != EN_IDLE);
  assign req_ready = (st == EN_IDLE);
  assign cur_block = blk_q;
  assign cur_node  = node_q;
  assign pick_vec  = (st == EN_INV) ? pend_q : old_sh_q;

  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = MK_NONE;
    msg_node  = pick_idx;
    if (st == EN_INV) begin
      msg_valid = 1'b1;
      msg_kind  = MK_INV;
    end else if (st == EN_FETCH) begin
      msg_valid = 1'b1;
      msg_kind  = owner_msg(k_q);
    end
  end

  assign reply_valid = (st == EN_DONE) && !drop_q && (k_q != RQ_WB);
  assign reply_fwd   = fwd_q;
  assign mem_wr      = (st == EN_DONE) && (fwd_q || wb_ok_q);

  always_comb begin
    dir_wr_en      = (st == EN_DONE) && !drop_q;
    dir_wr_state   = dir_after(k_q, old_st_q);
    dir_wr_sharers = old_sh_q;
    case (k_q)
      RQ_RD:   dir_wr_sharers = old_sh_q | req_bit;
      RQ_WR:   dir_wr_sharers = req_bit;
      RQ_WB:   dir_wr_sharers = '0;
      default: ;
    endcase
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_block,
  input  logic          fetch_ack,
  output logic          msg_valid,
  output logic [1:0]    msg_kind,
  output logic [NW-1:0] msg_node,
  output logic [BW-1:0] msg_block,
  output logic          reply_valid,
  output logic [NW-1:0] reply_node,
  output logic [BW-1:0] reply_block,
  output logic          reply_fwd,
  output logic          mem_wr,
  output logic [BW-1:0] mem_wr_block
);

  dstate_e          rd_state;
  logic [NODES-1:0] rd_sharers;
  logic [NODES-1:0] pick_vec;
  logic [NW-1:0]    pick_idx;
  logic [BW-1:0]    cur_block;
  logic [NW-1:0]    cur_node;
  logic             busy;
  logic             dir_wr_en;
  dstate_e          dir_wr_state;
  logic [NODES-1:0] dir_wr_sharers;

  dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (cur_block),
    .rd_state   (rd_state),
    .rd_sharers (rd_sharers),
    .wr_en      (dir_wr_en),
    .wr_idx     (cur_block),
    .wr_state   (dir_wr_state),
    .wr_sharers (dir_wr_sharers)
  );

  dir_pick #(.N(NODES)) u_pick (
    .vec (pick_vec),
    .idx (pick_idx)
  );

  dir_engine #(.NODES(NODES), .BLOCKS(BLOCKS)) u_eng (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_kind       (req_kind),
    .req_node       (req_node),
    .req_block      (req_block),
    .fetch_ack      (fetch_ack),
    .rd_state       (rd_state),
    .rd_sharers     (rd_sharers),
    .pick_idx       (pick_idx),
    .pick_vec       (pick_vec),
    .cur_block      (cur_block),
    .cur_node       (cur_node),
    .busy           (busy),
    .msg_valid      (msg_valid),
    .msg_kind       (msg_kind),
    .msg_node       (msg_node),
    .reply_valid    (reply_valid),
    .reply_fwd      (reply_fwd),
    .mem_wr         (mem_wr),
    .dir_wr_en      (dir_wr_en),
    .dir_wr_state   (dir_wr_state),
    .dir_wr_sharers (dir_wr_sharers)
  );

  assign msg_block    = cur_block;
  assign reply_node   = cur_node;
  assign reply_block  = cur_block;
  assign mem_wr_block = cur_block;

endmodule

// File: rtl/dir_chk.sv
module dir_chk
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             req_ready,
  input logic [NW-1:0]    cur_node,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [NW-1:0]    msg_node,
  input logic             reply_valid,
  input logic             dir_wr_en,
  input dstate_e          dir_wr_state,
  input logic [NODES-1:0] dir_wr_sharers
);

  assert_mod_one_holder_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_en && dir_wr_state == DS_MOD |-> $countones(dir_wr_sharers) == 1);

  assert_unc_no_holder_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_en && dir_wr_state == DS_UNC |-> dir_wr_sharers == '0);

  assert_shr_some_holder_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_en && dir_wr_state == DS_SHR |-> dir_wr_sharers != '0);

  assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_INV |-> msg_node != cur_node);

  assert_inv_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_INV && $past(msg_valid && msg_kind == MK_INV)
    |-> msg_node > $past(msg_node));

  assert_no_accept_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_update_only_in_txn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_en |-> busy);

  assert_msg_only_in_txn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> busy);

  assert_reply_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |=> !reply_valid);

endmodule

bind dir_home_ctrl dir_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .req_ready      (req_ready),
  .cur_node       (cur_node),
  .msg_valid      (msg_valid),
  .msg_kind       (msg_kind),
  .msg_node       (msg_node),
  .reply_valid    (reply_valid),
  .dir_wr_en      (dir_wr_en),
  .dir_wr_state   (dir_wr_state),
  .dir_wr_sharers (dir_wr_sharers)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;

  localparam int NODES  = 8;
  localparam int BLOCKS = 16;
  localparam int NW = $clog2(NODES);
  localparam int BW = $clog2(BLOCKS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [NW-1:0] req_node = '0;
  logic [BW-1:0] req_block = '0;
  logic          fetch_ack = 1'b0;
  logic          msg_valid;
  logic [1:0]    msg_kind;
  logic [NW-1:0] msg_node;
  logic [BW-1:0] msg_block;
  logic          reply_valid;
  logic [NW-1:0] reply_node;
  logic [BW-1:0] reply_block;
  logic          reply_fwd;
  logic          mem_wr;
  logic [BW-1:0] mem_wr_block;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench-side directory model: 0 Uncached, 1 Shared, 2 Modified.
  int               m_st [BLOCKS];
  logic [NODES-1:0] m_sh [BLOCKS];

  always #5 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_node(req_node), .req_block(req_block),
    .fetch_ack(fetch_ack), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_node(msg_node), .msg_block(msg_block), .reply_valid(reply_valid),
    .reply_node(reply_node), .reply_block(reply_block), .reply_fwd(reply_fwd),
    .mem_wr(mem_wr), .mem_wr_block(mem_wr_block)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Issues one request and checks everything it produces against the model.
  task automatic do_req(input int kind, input int node, input int blk,
                        input int ack_delay, input string tag);
    int st = m_st[blk];
    logic [NODES-1:0] sh = m_sh[blk];
    logic [NODES-1:0] rb = NODES'(1) << node;
    logic [NODES-1:0] e_inv = '0;
    int e_fk = 0, e_fn = 0, e_rep = 1, e_fwd = 0, e_mem = 0, n_st = st;
    logic [NODES-1:0] n_sh = sh;
    logic [NODES-1:0] inv_mask = '0;
    int inv_cnt = 0, last_inv = -1, order_ok = 1, fk = 0, fn = -1, fcnt = 0;
    int rep_cnt = 0, rfwd = 0, mem_cnt = 0, fields_ok = 1, waitc = 0;
    int ack_given = 0, done = 0;
    for (int i = 0; i < NODES; i++) if (sh[i]) e_fn = i;
    case (kind)
      0: begin
        if (st == 2) begin e_fk = 2; e_fwd = 1; e_mem = 1; end
        n_st = 1; n_sh = sh | rb;
      end
      1: begin
        if (st == 2) begin e_fk = 3; e_fwd = 1; e_mem = 1; end
        else if (st == 1) e_inv = sh & ~rb;
        n_st = 2; n_sh = rb;
      end
      2: begin
        e_rep = 0;
        if (st == 2 && sh == rb) begin e_mem = 1; n_st = 0; n_sh = '0; end
      end
      default: e_rep = 0;
    endcase

    while (!req_ready) @(negedge clk);
    req_kind  = 2'(kind);
    req_node  = NW'(node);
    req_block = BW'(blk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (fetch_ack) fetch_ack = 1'b0;
      if (req_ready) begin done = 1; break; end
      if (msg_valid) begin
        if (int'(msg_block) != blk) fields_ok = 0;
        if (msg_kind == 2'd1) begin
          inv_mask[msg_node] = 1'b1;
          inv_cnt++;
          if (int'(msg_node) <= last_inv) order_ok = 0;
          last_inv = int'(msg_node);
        end else begin
          fk = int'(msg_kind); fn = int'(msg_node); fcnt++;
          waitc = ack_delay;
        end
      end else if (waitc > 0) begin
        waitc--;
        if (waitc == 0) begin fetch_ack = 1'b1; ack_given = 1; end
      end
      if (reply_valid) begin
        rep_cnt++; rfwd = int'(reply_fwd);
        if (int'(reply_node) != node || int'(reply_block) != blk) fields_ok = 0;
      end
      if (mem_wr) begin
        mem_cnt++;
        if (int'(mem_wr_block) != blk) fields_ok = 0;
      end
      @(negedge clk);
    end
    fetch_ack = 1'b0;

    chk(done == 1, tag, "transaction completes", done, 1);
    chk(inv_mask == e_inv && inv_cnt == $countones(e_inv), tag,
        "invalidate target set", int'(inv_mask), int'(e_inv));
    chk(order_ok == 1, tag, "invalidate ascending order", order_ok, 1);
    chk((e_fk == 0 && fcnt == 0) || (fcnt == 1 && fk == e_fk && fn == e_fn), tag,
        "owner message kind*16+node", fk * 16 + fn, e_fk * 16 + (e_fk == 0 ? -1 : e_fn));
    chk(rep_cnt == e_rep && (e_rep == 0 || rfwd == e_fwd), tag,
        "reply count*2+fwd", rep_cnt * 2 + rfwd, e_rep * 2 + e_fwd);
    chk(mem_cnt == e_mem, tag, "memory write count", mem_cnt, e_mem);
    chk(fields_ok == 1, tag, "node/block fields", fields_ok, 1);
    if (e_fk != 0)
      chk(ack_given == 1, {tag, " R9"}, "stall held until fetch_ack", ack_given, 1);
    m_st[blk] = n_st;
    m_sh[blk] = n_sh;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(!msg_valid && !reply_valid && !mem_wr, "R1", "outputs quiet after reset",
        int'({msg_valid, reply_valid, mem_wr}), 0);
    // A fresh block is Uncached: a write miss needs no messages.
    do_req(1, 3, 0, 1, "R1");
  endtask

  task automatic t_read_clean();
    do_req(0, 1, 2, 1, "R2");
    do_req(0, 3, 2, 1, "R2");
    do_req(0, 1, 2, 1, "R2");
  endtask

  task automatic t_write_shared();
    do_req(0, 0, 4, 1, "R4");
    do_req(0, 7, 4, 1, "R4");
    do_req(0, 2, 4, 1, "R4");
    do_req(0, 5, 4, 1, "R4");
    do_req(1, 2, 4, 1, "R4");
  endtask

  task automatic t_write_modified();
    do_req(1, 6, 4, 1, "R5");
    do_req(1, 6, 0, 2, "R5");
  endtask

  task automatic t_read_modified();
    do_req(0, 1, 4, 6, "R3");
    // Both owner and reader must now be invalidated (R11 holder set).
    do_req(1, 3, 4, 1, "R11");
  endtask

  task automatic t_write_clean();
    do_req(1, 4, 9, 1, "R6");
    do_req(0, 5, 10, 1, "R6");
    do_req(1, 5, 10, 1, "R6");
  endtask

  task automatic t_writeback();
    do_req(2, 4, 9, 1, "R7");
    do_req(0, 0, 9, 1, "R7");
  endtask

  task automatic t_ignored();
    do_req(2, 1, 10, 1, "R8");
    do_req(2, 0, 9, 1, "R8");
    do_req(3, 5, 10, 1, "R8");
    // Entry of block 10 still Modified by node 5: fetch expected.
    do_req(0, 2, 10, 1, "R8");
  endtask

  task automatic t_idle();
    int quiet = 1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (msg_valid || reply_valid || mem_wr || !req_ready) quiet = 0;
    end
    chk(quiet == 1, "R10", "no activity without requests", quiet, 1);
  endtask

  initial begin
    for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_clean();
    t_write_shared();
    t_write_modified();
    t_read_modified();
    t_write_clean();
    t_writeback();
    t_ignored();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule